// File: doc/BRIEF.md
# Frame Offset Measurement Unit

This block measures how far a frame-evaluation input lags the frame pulse. A measurement is armed by a software start bit. The first frame boundary after the start opens a window one frame long. In that window the block timestamps the first active edge of the evaluation input, to half a clock period. The frame boundary that closes the window raises a completion flag and presents a 12-bit result: a whole-cycle count, plus a phase bit that tells which half of the clock period caught the edge.

The result is also recoded into the per-stream receive alignment setting that would cancel the measured skew: a 3-bit offset and a latch-edge select. The mode input picks which polarity is compared. In ST-BUS mode the frame pulse is active low and falling edges are compared. In GCI mode the frame pulse is active high and rising edges are compared. While the wide-frame-pulse mode input is high, no measurement can run. The reset input is assumed to be already synchronised to the clock.

Top module: `frame_offset_meter`

## Requirements
- R1: A rising edge of `start_i` is accepted only if a frame boundary was detected while `start_i` was low, since the last accepted start or since reset; otherwise it is ignored and `done_o` stays 0.
- R2: After an accepted start, the first frame boundary opens the window and the second one closes it; `done_o` reads 1 from the cycle after the closing boundary.
- R3: Cycle 0 begins at the clock edge where the opening boundary is detected. An edge in the high half of cycle j gives `result_o[10:0]` = j with `result_o[11]` = 1. An edge in the low half of cycle j gives `result_o[10:0]` = j+1 with `result_o[11]` = 0.
- R4: A falling edge of `start_i` clears `done_o` and `result_o` to 0 in the next cycle and abandons any measurement in progress.
- R5: With `gci_mode_i` = 0, a frame boundary is a falling `fp_i` and only falling `fe_i` edges count. With `gci_mode_i` = 1, rising edges are used for both, and falling edges are ignored.
- R6: While `wide_fp_i` is 1, no start is accepted, and a measurement in progress ends without `done_o` rising.
- R7: `ofs_code_o` equals `result_o[2:0]`, and `latch_edge_o` equals the inverse of `result_o[11]`.
- R8: The count saturates at 2047. If no edge arrives in the window, the result is {0, last cycle index of the window}, saturated at 2047.
- R9: Only the first qualifying edge in the window is recorded. While `done_o` is 1 and `start_i` stays high, `result_o` does not change.
- R10: `result_o` reads 0 whenever `done_o` is 0, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gci_mode_i | input | 1 | 0: ST-BUS polarity, 1: GCI polarity |
| wide_fp_i | input | 1 | Wide-frame-pulse mode; blocks measurement |
| fp_i | input | 1 | Frame pulse |
| fe_i | input | 1 | Frame-evaluation input being measured |
| start_i | input | 1 | Measurement start bit |
| done_o | output | 1 | Measurement complete |
| result_o | output | 12 | {phase, cycle count[10:0]} |
| ofs_code_o | output | 3 | Receive offset code derived from the result |
| latch_edge_o | output | 1 | Receive latch-edge select derived from the result |

## Verification
The bench places evaluation edges in both the high and low halves of random cycles. A design that mixes up the phases would report the count off by one and the phase bit flipped. It adds a second edge after the first, which catches a design that overwrites its capture. It leaves windows with no edge, and it uses a frame longer than 2047 cycles, where a counter that wraps would report a small count. It drops and raises the start bit without a frame boundary in between, and it asserts the wide-frame-pulse mode during a measurement. Both cases expose a sequencer that starts or completes when it should not.

// File: rtl/fom_pkg.sv
package fom_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_MEAS = 2'd2,
    S_DONE = 2'd3
  } fom_state_e;
endpackage

// File: rtl/fom_sampler.sv
// Samples the frame pulse on the rising edge and the evaluation input on
// both edges, then flags qualifying edges at each rising clock edge.
module fom_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic gci_i,
  input  logic fp_i,
  input  logic fe_i,
  output logic frm_edge_o,
  output logic fe_hi_edge_o,
  output logic fe_lo_edge_o
);
  logic fp_q, fe_lo_q, fe_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q    <= 1'b1;
      fe_lo_q <= 1'b0;
    end else begin
      fp_q    <= fp_i;
      fe_lo_q <= fe_i;
    end
  end

  // value held during the high half of the cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fe_hi_q <= 1'b0;
    else        fe_hi_q <= fe_i;
  end

  always_comb begin
    if (gci_i) begin
      frm_edge_o   = ~fp_q & fp_i;
      fe_hi_edge_o = ~fe_lo_q & fe_hi_q;
      fe_lo_edge_o = ~fe_hi_q & fe_i;
    end else begin
      frm_edge_o   = fp_q & ~fp_i;
      fe_hi_edge_o = fe_lo_q & ~fe_hi_q;
      fe_lo_edge_o = fe_hi_q & ~fe_i;
    end
  end
endmodule

// File: rtl/fom_counter.sv
// Saturating cycle counter, cleared at each frame boundary.
module fom_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_inc_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_inc_o;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fom_seq.sv
// Start/complete sequencing and first-edge capture.
module fom_seq
  import fom_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wfp_i,
  input  logic             frm_edge_i,
  input  logic             fe_hi_edge_i,
  input  logic             fe_lo_edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_inc_i,
  output logic             cnt_en_o,
  output logic             done_o,
  output logic [CNT_W-1:0] res_cnt_o,
  output logic             res_ph_o
);
  fom_state_e       state_q, state_d;
  logic             start_q, rearm_q, rearm_d, cap_q, cap_d, done_q, done_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] rcnt_q, rcnt_d;
  logic             start_rise, start_fall;

  assign start_rise = start_i & ~start_q;
  assign start_fall = ~start_i & start_q;

  always_comb begin
    state_d = state_q;
    rearm_d = rearm_q | (frm_edge_i & ~start_i);
    cap_d   = cap_q;
    done_d  = done_q;
    ph_d    = ph_q;
    rcnt_d  = rcnt_q;
    unique case (state_q)
      S_IDLE: if (start_rise && rearm_q && !wfp_i) begin
        state_d = S_WAIT;
        rearm_d = 1'b0;
        done_d  = 1'b0;
        rcnt_d  = '0;
        ph_d    = 1'b0;
      end
      S_WAIT: if (frm_edge_i) begin
        state_d = S_MEAS;
        cap_d   = 1'b0;
      end
      S_MEAS: begin
        if (!cap_q) begin
          if (fe_hi_edge_i) begin
            cap_d = 1'b1; rcnt_d = cnt_i; ph_d = 1'b1;
          end else if (fe_lo_edge_i && !frm_edge_i) begin
            cap_d = 1'b1; rcnt_d = cnt_inc_i; ph_d = 1'b0;
          end else if (frm_edge_i) begin
            rcnt_d = cnt_i; ph_d = 1'b0;   // window closed with no edge
          end
        end
        if (frm_edge_i) begin
          state_d = S_DONE;
          done_d  = 1'b1;
        end
      end
      default: ;
    endcase
    if (wfp_i && (state_q == S_WAIT || state_q == S_MEAS)) begin
      state_d = S_IDLE;
      done_d  = 1'b0;
    end
    if (start_fall) begin
      state_d = S_IDLE;
      done_d  = 1'b0;
      cap_d   = 1'b0;
      rcnt_d  = '0;
      ph_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= 1'b0;
      rearm_q <= 1'b0;
      cap_q   <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
      rearm_q <= rearm_d;
      cap_q   <= cap_d;
      done_q  <= done_d;
      ph_q    <= ph_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign cnt_en_o  = (state_q == S_MEAS);
  assign done_o    = done_q;
  assign res_cnt_o = rcnt_q;
  assign res_ph_o  = ph_q;
endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
  parameter int CNT_W = 11,
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gci_mode_i,
  input  logic             wide_fp_i,
  input  logic             fp_i,
  input  logic             fe_i,
  input  logic             start_i,
  output logic             done_o,
  output logic [CNT_W:0]   result_o,
  output logic [OFS_W-1:0] ofs_code_o,
  output logic             latch_edge_o
);
  localparam int RES_W = CNT_W + 1;

  logic             frm_edge, fe_hi_edge, fe_lo_edge, cnt_en;
  logic [CNT_W-1:0] cnt, cnt_inc, res_cnt;
  logic             res_ph;

  fom_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .gci_i(gci_mode_i), .fp_i(fp_i), .fe_i(fe_i),
    .frm_edge_o(frm_edge), .fe_hi_edge_o(fe_hi_edge), .fe_lo_edge_o(fe_lo_edge)
  );

  fom_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(frm_edge), .en_i(cnt_en),
    .cnt_o(cnt), .cnt_inc_o(cnt_inc)
  );

  fom_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wfp_i(wide_fp_i),
    .frm_edge_i(frm_edge), .fe_hi_edge_i(fe_hi_edge), .fe_lo_edge_i(fe_lo_edge),
    .cnt_i(cnt), .cnt_inc_i(cnt_inc), .cnt_en_o(cnt_en),
    .done_o(done_o), .res_cnt_o(res_cnt), .res_ph_o(res_ph)
  );

  logic [RES_W-1:0] res_full;
  assign res_full     = {res_ph, res_cnt};
  assign result_o     = done_o ? res_full : '0;
  assign ofs_code_o   = result_o[OFS_W-1:0];
  assign latch_edge_o = ~result_o[RES_W-1];
endmodule

// File: rtl/fom_checker.sv
module fom_checker #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             wide_fp_i,
  input logic             frm_edge,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  // R2: completion only follows a detected frame boundary
  a_r2_done_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(frm_edge));

  // R4: start falling clears flag and result
  a_r4_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_i) && !start_i) |=> (!done_o && result_o == '0));

  // R6: no completion out of wide-frame-pulse mode
  a_r6_wfp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !$past(wide_fp_i));

  // R9: the result holds while completion stays set
  a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(result_o));
endmodule

bind frame_offset_meter fom_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_fp_i(wide_fp_i),
  .frm_edge(frm_edge), .done_o(done_o), .result_o(result_o)
);

// File: tb/tb_frame_offset_meter.sv
module tb_frame_offset_meter;
  logic        clk, rst_n, gci, wfp, fp, fe, start;
  logic        done, latch;
  logic [11:0] res;
  logic [2:0]  code;
  int          n_chk, n_fail;
  bit          ended;

  frame_offset_meter dut (
    .clk(clk), .rst_n(rst_n), .gci_mode_i(gci), .wide_fp_i(wfp), .fp_i(fp),
    .fe_i(fe), .start_i(start), .done_o(done), .result_o(res),
    .ofs_code_o(code), .latch_edge_o(latch)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic logic act_lvl();
    return gci;
  endfunction

  function automatic logic [11:0] exp_res(input int h, input int len);
    int c; logic ph;
    if (h < 0)            begin c = len - 1;   ph = 1'b0; end
    else if (h % 2 == 0)  begin c = h / 2;     ph = 1'b1; end
    else                  begin c = h / 2 + 1; ph = 1'b0; end
    if (c > 2047) c = 2047;
    return {ph, 11'(c)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic half(input int x, input int h1, input int h2);
    if (x == h1 || x == h2)         fe = act_lvl();
    if (x == h1 + 2 || x == h2 + 2) fe = ~act_lvl();
  endtask

  // called just after the clock edge that detected a frame boundary
  task automatic frame(input int len, input int h1, input int h2);
    fp = ~act_lvl();
    fe = ~act_lvl();
    for (int c = 0; c < len; c++) begin
      half(2 * c, h1, h2);
      if (c == len - 1) fp = act_lvl();
      @(negedge clk); #1;
      half(2 * c + 1, h1, h2);
      @(posedge clk); #1;
    end
  endtask

  task automatic resync();
    fp = ~act_lvl();
    fe = ~act_lvl();
    @(posedge clk); #1;
    fp = act_lvl();
    @(posedge clk); #1;
  endtask

  task automatic measure(input int len, input int h1, input int h2);
    start = 1'b0;
    frame(len, -10, -10);
    start = 1'b1;
    frame(len, -10, -10);
    chk("R10 zero while pending", {20'd0, res}, 32'd0);
    frame(len, h1, h2);
  endtask

  task automatic verify(input string req, input int len, input int h1);
    logic [11:0] e;
    e = exp_res(h1, len);
    chk("R2 done", {31'd0, done}, 32'd1);
    chk(req, {20'd0, res}, {20'd0, e});
    chk("R7 code", {29'd0, code}, {29'd0, e[2:0]});
    chk("R7 latch", {31'd0, latch}, {31'd0, ~e[11]});
  endtask

  initial begin
    n_chk = 0; n_fail = 0; ended = 1'b0;
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    int len, h1, h2;
    logic [11:0] held;
    void'($urandom(32'd7321));
    rst_n = 1'b0; gci = 1'b0; wfp = 1'b0; fp = 1'b1; fe = 1'b1; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset result", {20'd0, res}, 32'd0);
    chk("R7 reset latch", {31'd0, latch}, 32'd1);
    @(posedge clk); #1;
    resync();

    // directed ST-BUS corners
    measure(40, 0, -10);  verify("R3 high half c0", 40, 0);
    measure(40, 1, -10);  verify("R3 low half c0", 40, 1);
    measure(40, 13, -10); verify("R3 low half c6", 40, 13);
    measure(40, 10, 30);  verify("R9 first edge only", 40, 10);
    measure(40, -10, -10); verify("R8 no edge", 40, -10);

    // R9: result holds with further edges while done
    held = res;
    frame(40, 4, 20);
    chk("R9 done held", {31'd0, done}, 32'd1);
    chk("R9 result held", {20'd0, res}, {20'd0, held});

    // R4 clear, then R1 restart without a low frame boundary
    start = 1'b0;
    @(posedge clk); #1;
    chk("R4 done cleared", {31'd0, done}, 32'd0);
    chk("R4 result cleared", {20'd0, res}, 32'd0);
    @(posedge clk); #1;
    start = 1'b1;
    frame(40, -10, -10);
    frame(40, -10, -10);
    frame(40, 6, -10);
    chk("R1 start not armed", {31'd0, done}, 32'd0);

    // R6: wide-frame-pulse mode blocks measurement
    wfp = 1'b1;
    measure(40, 8, -10);
    chk("R6 blocked done", {31'd0, done}, 32'd0);
    chk("R6 blocked result", {20'd0, res}, 32'd0);
    wfp = 1'b0;
    measure(40, 8, -10); verify("R6 after release", 40, 8);

    for (int i = 0; i < 6; i++) begin
      len = 24 + int'($urandom % 40);
      h1  = int'($urandom % (2 * len - 5));
      h2  = ($urandom % 2 == 1) ? h1 + 3 + int'($urandom % 8) : -10;
      if (h2 > 2 * len - 5) h2 = -10;
      measure(len, h1, h2); verify("R3 random st", len, h1);
    end

    // GCI polarity
    gci = 1'b1;
    resync();
    measure(40, 7, -10); verify("R5 gci", 40, 7);
    measure(40, 2, 9);   verify("R5 gci two edges", 40, 2);
    for (int i = 0; i < 6; i++) begin
      len = 24 + int'($urandom % 40);
      h1  = int'($urandom % (2 * len - 5));
      h2  = ($urandom % 2 == 1) ? h1 + 3 + int'($urandom % 8) : -10;
      if (h2 > 2 * len - 5) h2 = -10;
      measure(len, h1, h2); verify("R5 random gci", len, h1);
    end

    // saturation on a long frame
    measure(2100, 4120, -10); verify("R8 saturated edge", 2100, 4120);
    measure(2100, -10, -10);  verify("R8 saturated no edge", 2100, -10);

    report();
  end
endmodule